// File: doc/BRIEF.md
# Shift and Rotate Unit with Single Flag Bit

This block performs the shift and rotate operations of a 32-bit processor whose only condition state is one flag bit, called T here. A 4-bit operation code picks the operation. The operation reads the operand, an amount register and the current T. It returns the shifted value and the next value of T.

There are three groups of operations:
- Dynamic shifts take their direction from the sign of the amount register.
- Single-bit shifts and rotates exchange a bit with T.
- Fixed logical shifts move the operand by 2, 8 or 16 places.

Inputs are captured on one clock edge, and both outputs are registered. A result therefore appears one cycle after its inputs are presented. Writing the result back to a register file is done by the surrounding pipeline.

Top module: `shrot_unit`

## Requirements
- R1: A synchronous active-high reset clears the result output and the T output to 0. After reset, the result and T for the inputs present at a rising edge appear on the outputs just after that edge, so the latency is one cycle.
- R2: Dynamic shift, arithmetic op code 0 or logical op code 1, with amount bit 31 clear: the result is the operand shifted left by amount[4:0]. An amount of 0 passes the operand through unchanged.
- R3: Dynamic shift with amount bit 31 set and amount[4:0] nonzero: the result is the operand shifted right by 32 minus amount[4:0]. Op code 0 fills with the sign bit and op code 1 fills with zeros.
- R4: Dynamic shift with amount bit 31 set and amount[4:0] equal to zero:
  - op code 1 yields 0;
  - op code 0 yields all ones when operand bit 31 is set;
  - op code 0 yields 0 when operand bit 31 is clear.
- R5: Rotate left through T, op code 2: the result is the operand shifted left by one with the old T in bit 0. The new T is the old operand bit 31.
- R6: Rotate right through T, op code 3: the result is the operand shifted right by one with the old T in bit 31. The new T is the old operand bit 0.
- R7: Plain rotates move the bit that leaves one end to the other end, and that bit also becomes the new T:
  - op code 4 rotates left by one;
  - op code 5 rotates right by one.
- R8: Single-bit shifts send the bit shifted out into T:
  - op code 6 is an arithmetic left shift by one;
  - op code 8 is a logical left shift by one;
  - op code 9 is a logical right shift by one, with bit 31 cleared;
  - op code 7 is an arithmetic right shift by one, which keeps bit 31.
- R9: Fixed logical shifts leave T equal to the incoming T. The op codes are:
  - left by 2 is op code 10, right by 2 is op code 11;
  - left by 8 is op code 12, right by 8 is op code 13;
  - left by 16 is op code 14, right by 16 is op code 15.
- R10: Both dynamic shifts, op codes 0 and 1, leave T equal to the incoming T, whatever the amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| operand_i | input | WIDTH | Value to shift |
| amount_i | input | WIDTH | Signed amount register for the dynamic shifts |
| t_i | input | 1 | Current T flag |
| result_o | output | WIDTH | Registered result |
| t_o | output | 1 | Registered next T flag |

## Verification
The sweep targets the case of a negative amount whose low five bits are zero. A design that treated it as a right shift by 0 would return the operand unchanged where 0 or the sign fill is required. Amounts of 1 and 31 with the sign bit set catch an off-by-one in the 32-minus-amount conversion: such a design shifts by 32 instead of 31, or by 0 instead of 1. Running every op code with T at both 0 and 1 exposes designs that modify T in the dynamic or fixed shifts. The same runs catch a swapped insertion point in the rotates through T, and an arithmetic right shift that drops the sign bit.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DSHA   = 4'd0,
    OP_DSHL   = 4'd1,
    OP_ROTCL  = 4'd2,
    OP_ROTCR  = 4'd3,
    OP_ROTL   = 4'd4,
    OP_ROTR   = 4'd5,
    OP_SHAL   = 4'd6,
    OP_SHAR   = 4'd7,
    OP_SHLL   = 4'd8,
    OP_SHLR   = 4'd9,
    OP_FXL_A  = 4'd10,
    OP_FXR_A  = 4'd11,
    OP_FXL_B  = 4'd12,
    OP_FXR_B  = 4'd13,
    OP_FXL_C  = 4'd14,
    OP_FXR_C  = 4'd15
  } shrot_op_e;
endpackage

// File: rtl/shrot_barrel.sv
// Logarithmic barrel shifter; direction chosen at elaboration.
module shrot_barrel #(
  parameter int WIDTH    = 32,
  parameter bit RIGHT    = 1'b0,
  localparam int AMT_W   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [WIDTH-1:0] moved;
    if (RIGHT) begin : g_right
      assign moved = {{STEP{fill_i}}, stage[s][WIDTH-1:STEP]};
    end else begin : g_left
      assign moved = {stage[s][WIDTH-1-STEP:0], {STEP{1'b0}}};
    end
    assign stage[s+1] = amt_i[s] ? moved : stage[s];
  end

  assign data_o = stage[AMT_W];
endmodule

// File: rtl/shrot_dyn.sv
// Sign-directed dynamic shift.
module shrot_dyn #(
  parameter int WIDTH  = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] amount_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] result_o
);
  logic [AMT_W-1:0] low_amt;
  logic [AMT_W-1:0] right_amt;
  logic             negative;
  logic             sign_fill;
  logic [WIDTH-1:0] left_res;
  logic [WIDTH-1:0] right_res;

  assign low_amt   = amount_i[AMT_W-1:0];
  assign right_amt = AMT_W'(~low_amt + 1'b1);
  assign negative  = amount_i[WIDTH-1];
  assign sign_fill = arith_i & operand_i[WIDTH-1];

  shrot_barrel #(.WIDTH(WIDTH), .RIGHT(1'b0)) u_left (
    .data_i (operand_i),
    .amt_i  (low_amt),
    .fill_i (1'b0),
    .data_o (left_res)
  );

  shrot_barrel #(.WIDTH(WIDTH), .RIGHT(1'b1)) u_right (
    .data_i (operand_i),
    .amt_i  (right_amt),
    .fill_i (sign_fill),
    .data_o (right_res)
  );

  always_comb begin
    if (!negative)             result_o = left_res;
    else if (low_amt != '0)    result_o = right_res;
    else                       result_o = {WIDTH{sign_fill}};
  end
endmodule

// File: rtl/shrot_bit.sv
// Single-bit shifts and rotates that exchange a bit with T.
module shrot_bit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  shrot_op_e        op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             t_i,
  output logic [WIDTH-1:0] result_o,
  output logic             t_o
);
  logic msb, lsb;
  assign msb = operand_i[WIDTH-1];
  assign lsb = operand_i[0];

  always_comb begin
    result_o = operand_i;
    t_o      = t_i;
    unique case (op_i)
      OP_ROTCL: begin result_o = {operand_i[WIDTH-2:0], t_i};  t_o = msb; end
      OP_ROTCR: begin result_o = {t_i, operand_i[WIDTH-1:1]};  t_o = lsb; end
      OP_ROTL:  begin result_o = {operand_i[WIDTH-2:0], msb};  t_o = msb; end
      OP_ROTR:  begin result_o = {lsb, operand_i[WIDTH-1:1]};  t_o = lsb; end
      OP_SHAL,
      OP_SHLL:  begin result_o = {operand_i[WIDTH-2:0], 1'b0}; t_o = msb; end
      OP_SHAR:  begin result_o = {msb, operand_i[WIDTH-1:1]};  t_o = lsb; end
      OP_SHLR:  begin result_o = {1'b0, operand_i[WIDTH-1:1]}; t_o = lsb; end
      default:  begin result_o = operand_i; t_o = t_i; end
    endcase
  end
endmodule

// File: rtl/shrot_fix.sv
// Fixed-distance logical shifts; T is never touched here.
module shrot_fix
  import shrot_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHIFT_A = 2,
  parameter int SHIFT_B = 8,
  parameter int SHIFT_C = 16
) (
  input  shrot_op_e        op_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o
);
  localparam int NUM = 3;
  localparam int DIST [NUM] = '{SHIFT_A, SHIFT_B, SHIFT_C};

  logic [WIDTH-1:0] lft [NUM];
  logic [WIDTH-1:0] rgt [NUM];

  for (genvar k = 0; k < NUM; k++) begin : g_dist
    assign lft[k] = operand_i << DIST[k];
    assign rgt[k] = operand_i >> DIST[k];
  end

  always_comb begin
    unique case (op_i)
      OP_FXL_A: result_o = lft[0];
      OP_FXR_A: result_o = rgt[0];
      OP_FXL_B: result_o = lft[1];
      OP_FXR_B: result_o = rgt[1];
      OP_FXL_C: result_o = lft[2];
      OP_FXR_C: result_o = rgt[2];
      default:  result_o = operand_i;
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] amount_i,
  input  logic             t_i,
  output logic [WIDTH-1:0] result_o,
  output logic             t_o
);
  shrot_op_e        op;
  logic [WIDTH-1:0] dyn_res, bit_res, fix_res;
  logic             bit_t;
  logic [WIDTH-1:0] next_res;
  logic             next_t;

  assign op = shrot_op_e'(op_i);

  shrot_dyn #(.WIDTH(WIDTH)) u_dyn (
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .arith_i   (op == OP_DSHA),
    .result_o  (dyn_res)
  );

  shrot_bit #(.WIDTH(WIDTH)) u_bit (
    .op_i      (op),
    .operand_i (operand_i),
    .t_i       (t_i),
    .result_o  (bit_res),
    .t_o       (bit_t)
  );

  shrot_fix #(.WIDTH(WIDTH)) u_fix (
    .op_i      (op),
    .operand_i (operand_i),
    .result_o  (fix_res)
  );

  always_comb begin
    unique case (op)
      OP_DSHA, OP_DSHL: begin next_res = dyn_res; next_t = t_i; end
      OP_ROTCL, OP_ROTCR, OP_ROTL, OP_ROTR,
      OP_SHAL, OP_SHAR, OP_SHLL, OP_SHLR:
                        begin next_res = bit_res; next_t = bit_t; end
      default:          begin next_res = fix_res; next_t = t_i; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      t_o      <= 1'b0;
    end else begin
      result_o <= next_res;
      t_o      <= next_t;
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter int WIDTH  = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] operand_i,
  input logic [WIDTH-1:0] amount_i,
  input logic             t_i,
  input logic [WIDTH-1:0] result_o,
  input logic             t_o
);
  logic is_dyn, is_fix, low_zero;
  assign is_dyn   = (op_i == OP_DSHA) || (op_i == OP_DSHL);
  assign is_fix   = op_i >= OP_FXL_A;
  assign low_zero = amount_i[AMT_W-1:0] == '0;

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && t_o == 1'b0));

  p_dyn_left_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (is_dyn && !amount_i[WIDTH-1] && low_zero) |=> result_o == $past(operand_i));

  p_neg_zero_logic_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DSHL && amount_i[WIDTH-1] && low_zero) |=> result_o == '0);

  p_rotcl_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ROTCL) |=> (result_o[0] == $past(t_i) && t_o == $past(operand_i[WIDTH-1])));

  p_rotcr_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ROTCR) |=> (result_o[WIDTH-1] == $past(t_i) && t_o == $past(operand_i[0])));

  p_rotl_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ROTL) |=> (result_o[0] == t_o && t_o == $past(operand_i[WIDTH-1])));

  p_shar_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SHAR) |=> (result_o[WIDTH-1] == $past(operand_i[WIDTH-1]) && t_o == $past(operand_i[0])));

  p_fix_keeps_t_r9: assert property (@(posedge clk) disable iff (rst)
    is_fix |=> t_o == $past(t_i));

  p_dyn_keeps_t_r10: assert property (@(posedge clk) disable iff (rst)
    is_dyn |=> t_o == $past(t_i));
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .operand_i(operand_i),
  .amount_i(amount_i), .t_i(t_i), .result_o(result_o), .t_o(t_o)
);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] operand_i = '0;
  logic [W-1:0] amount_i = '0;
  logic         t_i = 1'b0;
  logic [W-1:0] result_o;
  logic         t_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shrot_unit #(.WIDTH(W)) u_shrot_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .operand_i(operand_i),
    .amount_i(amount_i), .t_i(t_i), .result_o(result_o), .t_o(t_o)
  );

  // Expected {T, result} from the requirements.
  function automatic logic [W:0] model(input int op, input logic [W-1:0] a,
                                       input logic [W-1:0] m, input logic t);
    int unsigned n;
    logic [W-1:0] r;
    logic nt;
    n = m % 32;
    nt = t;
    r = a;
    case (op)
      0, 1: begin // R2 R3 R4 R10
        if (!m[W-1]) r = a << n;
        else if (n != 0) r = (op == 0) ? W'($signed(a) >>> (32 - n)) : a >> (32 - n);
        else r = (op == 0 && a[W-1]) ? '1 : '0;
      end
      2: begin r = (a * 2) | W'(t);             nt = a[W-1]; end // R5
      3: begin r = (a / 2) | (W'(t) << 31);     nt = a[0];   end // R6
      4: begin r = (a * 2) | W'(a[W-1]);        nt = a[W-1]; end // R7
      5: begin r = (a / 2) | (W'(a[0]) << 31);  nt = a[0];   end // R7
      6, 8: begin r = a * 2;                    nt = a[W-1]; end // R8
      7: begin r = W'($signed(a) >>> 1);        nt = a[0];   end // R8
      9: begin r = a / 2;                       nt = a[0];   end // R8
      10: r = a * 4;       11: r = a / 4;        // R9
      12: r = a * 256;     13: r = a / 256;
      14: r = a * 65536;   15: r = a / 65536;
      default: r = a;
    endcase
    return {nt, r};
  endfunction

  function automatic string tag_of(input int op, input logic [W-1:0] m);
    if (op <= 1) begin
      if (!m[W-1]) return "R2/R10";
      if (m[4:0] != 0) return "R3/R10";
      return "R4/R10";
    end
    case (op)
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6, 7, 8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got T=%0b res=%h, expected T=%0b res=%h",
               tag, act[W], act[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  logic [W-1:0] operands [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                                 32'h7FFF_FFFE, 32'h1234_5678, 32'hDEAD_BEEF,
                                 32'h0000_0001, 32'h8000_0000};
  logic [W-1:0] amounts [10] = '{32'd0, 32'd1, 32'd31, 32'd16, 32'h0000_0025,
                                 32'hFFFF_FFFF, 32'hFFFF_FFE1, 32'hFFFF_FFE0,
                                 32'h8000_0000, 32'hFFFF_FFF0};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {t_o, result_o}, '0);
    op_i = 4'd2; operand_i = 32'h8000_0000; t_i = 1'b1;
    @(negedge clk);
    check("R1", {t_o, result_o}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {t_o, result_o}, {1'b1, 32'h0000_0001});

    for (int op = 0; op < 16; op++) begin
      for (int ai = 0; ai < 8; ai++) begin
        for (int mi = 0; mi < 10; mi++) begin
          for (int tv = 0; tv < 2; tv++) begin
            op_i = 4'(op); operand_i = operands[ai];
            amount_i = amounts[mi]; t_i = tv[0];
            @(negedge clk);
            check(tag_of(op, amounts[mi]), {t_o, result_o},
                  model(op, operands[ai], amounts[mi], tv[0]));
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule